// File: doc/BRIEF.md
# Rotation-Order FFT Address Generator

This block sequences the memory traffic of an in-place, memory-based radix-r decimation-in-frequency FFT of fixed length N = r^n. A stage counter and a butterfly counter step through all (N/r)·n butterflies of one transform. For each butterfly the block emits r operand locations, one per digit value d in 0..r-1. Each location is a (bank, in-bank index) pair, so a memory split into r banks can deliver all r operands of the butterfly in the same cycle. The same pairs serve the reads and, after the datapath latency, the write-back.

The one-dimensional operand address is formed by placing d as the top base-r digit above the butterfly count and rotating the whole n-digit word right by the stage number. Butterflies that share a twiddle factor are therefore visited next to each other, not in top-to-bottom order. Each address is steered to the bank given by the sum of its base-r digits modulo r. The in-bank index is the address with its lowest digit removed. A coefficient index accompanies each butterfly for the twiddle lookup.

A one-cycle start request launches a transform. Valid is high for every butterfly, and a one-cycle done pulse follows the last one.

Top module: `fftag_addr_gen`

## Requirements
- R1: While reset is applied, and until a start is accepted, `valid_o` and `done_o` are 0.
- R2: A `start_i` sampled high while idle makes `valid_o` go high on the following cycle. `valid_o` then stays high for exactly (N/r)·n consecutive cycles.
- R3: Within a transform the butterfly count i runs 0..N/r-1 for each stage k, and the stages run 0..n-1 in ascending order; one butterfly is emitted per valid cycle.
- R4: The address of operand d is the n-digit word {d, i} rotated right by k base-r digits. Operand d occupies slice d of `bank_o` (DW bits each) and of `index_o` (BW bits each), with slice 0 at the least significant end.
- R5: For r=2, N=16 the operand pairs are <i, i+8> in stage 0; <0,4>, <8,12>, <1,5>, <9,13>, <2,6>, <10,14>, <3,7>, <11,15> in stage 1; and <2i, 2i+1> in stage 3.
- R6: The bank of an address is the sum of its base-r digits modulo r. The r banks of one butterfly are all different.
- R7: The in-bank index of an address is the address shifted right by one base-r digit.
- R8: `coef_o` equals i with its k least significant base-r digits forced to zero. It is therefore 0 throughout the last stage.
- R9: `done_o` is high for exactly one cycle, the cycle after the last valid butterfly, and `valid_o` is low in that cycle.
- R10: `start_i` sampled while a transform is running is ignored: the butterfly sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Transform launch request, sampled while idle |
| valid_o | output | 1 | High while a butterfly's addresses are presented |
| bank_o | output | RADIX*DW | Bank of each operand, operand d in slice d |
| index_o | output | RADIX*BW | In-bank index of each operand, operand d in slice d |
| coef_o | output | BW | Twiddle exponent base for the current butterfly |
| done_o | output | 1 | One-cycle pulse after the last butterfly |

## Verification
All address outputs are derived combinationally from the counter registers. A start sampled at one edge therefore shows its first butterfly during the cycle that follows, and every later edge advances exactly one butterfly. The done pulse occupies the cycle after the last butterfly. The bench drives inputs on the falling edge and reads outputs on the next falling edge, half a cycle after the register update. It keeps its own stage and butterfly count, advanced once per cycle, so every sample is compared with the model value for that cycle. Both a binary and a quaternary configuration are run. Extra start pulses are injected mid-transform, and one run starts again in the same cycle that done is high.

// File: rtl/fftag_pkg.sv
package fftag_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Digit distance moved by barrel layer s, folded into one full turn of ndig digits.
  function automatic int rot_step(input int s, input int ndig);
    return (1 << s) % ndig;
  endfunction

endpackage

// File: rtl/fftag_rst_sync.sv
module fftag_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fftag_seq.sv
module fftag_seq #(
  parameter int NDIG = 4,
  parameter int BW   = 3,
  parameter int SW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          active_o,
  output logic [SW-1:0] stage_o,
  output logic [BW-1:0] bfly_o,
  output logic          done_o
);

  import fftag_pkg::*;

  seq_state_e    state_q, state_d;
  logic [SW-1:0] stage_q, stage_d;
  logic [BW-1:0] bfly_q,  bfly_d;
  logic          done_q,  done_d;
  logic          cnt_en;
  logic          last_bfly;
  logic          last_stage;

  // Butterfly count spans exactly r^(n-1) = 2^BW values, so the wrap is all-ones.
  assign last_bfly  = &bfly_q;
  assign last_stage = (stage_q == SW'(NDIG - 1));

  // Registers only move while running, on a launch, or to clear the done pulse.
  assign cnt_en = (state_q == SEQ_RUN) | start_i | done_q;

  always_comb begin
    state_d = state_q;
    stage_d = stage_q;
    bfly_d  = bfly_q;
    done_d  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_RUN;
          stage_d = '0;
          bfly_d  = '0;
        end
      end
      SEQ_RUN: begin
        bfly_d = bfly_q + BW'(1);
        if (last_bfly) begin
          if (last_stage) begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
          end else begin
            stage_d = stage_q + SW'(1);
          end
        end
      end
      default: begin
        state_d = SEQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      stage_q <= '0;
      bfly_q  <= '0;
      done_q  <= 1'b0;
    end else if (cnt_en) begin
      state_q <= state_d;
      stage_q <= stage_d;
      bfly_q  <= bfly_d;
      done_q  <= done_d;
    end
  end

  assign active_o = (state_q == SEQ_RUN);
  assign stage_o  = stage_q;
  assign bfly_o   = bfly_q;
  assign done_o   = done_q;

endmodule

// File: rtl/fftag_rotate.sv
module fftag_rotate #(
  parameter int DW   = 1,
  parameter int NDIG = 4,
  parameter int SW   = 2,
  localparam int AW  = DW * NDIG,
  localparam int BW  = DW * (NDIG - 1)
) (
  input  logic [SW-1:0] stage_i,
  input  logic [DW-1:0] lead_i,
  input  logic [BW-1:0] bfly_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] layer [SW+1];

  assign layer[0] = {lead_i, bfly_i};

  // Log-depth barrel: layer s turns the word right by 2^s digits when stage bit s is set.
  for (genvar s = 0; s < SW; s++) begin : g_layer
    localparam int SH = fftag_pkg::rot_step(s, NDIG);
    if (SH == 0) begin : g_pass
      assign layer[s+1] = layer[s];
    end else begin : g_turn
      assign layer[s+1] = stage_i[s] ? {layer[s][SH*DW-1:0], layer[s][AW-1:SH*DW]}
                                     : layer[s];
    end
  end

  assign addr_o = layer[SW];

endmodule

// File: rtl/fftag_bank_map.sv
module fftag_bank_map #(
  parameter int DW   = 1,
  parameter int NDIG = 4,
  localparam int AW  = DW * NDIG,
  localparam int BW  = DW * (NDIG - 1)
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] bank_o,
  output logic [BW-1:0] index_o
);

  logic [DW-1:0] digit_acc;

  // A DW-bit accumulator wraps at r, which gives the digit sum modulo r directly.
  always_comb begin
    digit_acc = '0;
    for (int j = 0; j < NDIG; j++) begin
      digit_acc = digit_acc + addr_i[j*DW +: DW];
    end
  end

  assign bank_o  = digit_acc;
  assign index_o = addr_i[AW-1:DW];

endmodule

// File: rtl/fftag_addr_gen.sv
module fftag_addr_gen #(
  parameter int RADIX = 2,
  parameter int NDIG  = 4,
  localparam int DW   = $clog2(RADIX),
  localparam int AW   = DW * NDIG,
  localparam int BW   = DW * (NDIG - 1),
  localparam int SW   = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                valid_o,
  output logic [RADIX*DW-1:0] bank_o,
  output logic [RADIX*BW-1:0] index_o,
  output logic [BW-1:0]       coef_o,
  output logic                done_o
);

  logic          rst_sync_n;
  logic          active_w;
  logic [SW-1:0] stage_w;
  logic [BW-1:0] bfly_w;
  logic          done_w;

  fftag_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fftag_seq #(
    .NDIG (NDIG),
    .BW   (BW),
    .SW   (SW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .active_o (active_w),
    .stage_o  (stage_w),
    .bfly_o   (bfly_w),
    .done_o   (done_w)
  );

  // One rotate + bank-map lane per operand digit value.
  for (genvar d = 0; d < RADIX; d++) begin : g_lane
    logic [AW-1:0] lane_addr;

    fftag_rotate #(
      .DW   (DW),
      .NDIG (NDIG),
      .SW   (SW)
    ) u_rot (
      .stage_i (stage_w),
      .lead_i  (DW'(d)),
      .bfly_i  (bfly_w),
      .addr_o  (lane_addr)
    );

    fftag_bank_map #(
      .DW   (DW),
      .NDIG (NDIG)
    ) u_map (
      .addr_i  (lane_addr),
      .bank_o  (bank_o[d*DW +: DW]),
      .index_o (index_o[d*BW +: BW])
    );
  end

  // Twiddle base: butterfly count with the k lowest digits cleared.
  always_comb begin
    coef_o = bfly_w;
    for (int j = 0; j < NDIG - 1; j++) begin
      if (j < int'(stage_w)) begin
        coef_o[j*DW +: DW] = '0;
      end
    end
  end

  assign valid_o = active_w;
  assign done_o  = done_w;

endmodule

// File: rtl/fftag_addr_gen_chk.sv
module fftag_addr_gen_chk #(
  parameter int RADIX = 2,
  parameter int NDIG  = 4,
  parameter int DW    = 1,
  parameter int BW    = 3,
  parameter int SW    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                valid_o,
  input logic                done_o,
  input logic [SW-1:0]       stage_i,
  input logic [RADIX*DW-1:0] bank_i,
  input logic [BW-1:0]       coef_i
);

  logic [RADIX-1:0] bank_seen;

  always_comb begin
    bank_seen = '0;
    for (int d = 0; d < RADIX; d++) begin
      bank_seen[bank_i[d*DW +: DW]] = 1'b1;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(start_i));

  // R6
  banks_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($countones(bank_seen) == RADIX));

  // R3
  stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(stage_i) < NDIG));

  // R3
  stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |->
      ((stage_i == $past(stage_i)) || (stage_i == $past(stage_i) + SW'(1))));

  // R8
  coef_last_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (stage_i == SW'(NDIG - 1))) |-> (coef_i == '0));

endmodule

bind fftag_addr_gen fftag_addr_gen_chk #(
  .RADIX (RADIX),
  .NDIG  (NDIG),
  .DW    (DW),
  .BW    (BW),
  .SW    (SW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .valid_o (valid_o),
  .done_o  (done_o),
  .stage_i (stage_w),
  .bank_i  (bank_o),
  .coef_i  (coef_o)
);

// File: tb/fftag_addr_gen_tb.sv
`timescale 1ns/1ps
module fftag_addr_gen_tb;

  logic clk;
  logic rst_n;
  logic start2, start4;

  logic       valid2, done2;
  logic [1:0] bank2;
  logic [5:0] index2;
  logic [2:0] coef2;

  logic        valid4, done4;
  logic [7:0]  bank4;
  logic [15:0] index4;
  logic [3:0]  coef4;

  int tests;
  int fails;
  int sel;

  logic        v_valid, v_done;
  logic [15:0] v_bank;
  logic [31:0] v_index;
  logic [15:0] v_coef;

  fftag_addr_gen #(.RADIX(2), .NDIG(4)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start2),
    .valid_o (valid2), .bank_o (bank2), .index_o (index2),
    .coef_o (coef2), .done_o (done2)
  );

  fftag_addr_gen #(.RADIX(4), .NDIG(3)) u_dut_r4 (
    .clk (clk), .rst_n (rst_n), .start_i (start4),
    .valid_o (valid4), .bank_o (bank4), .index_o (index4),
    .coef_o (coef4), .done_o (done4)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb begin
    if (sel == 0) begin
      v_valid = valid2;  v_done = done2;
      v_bank  = 16'(bank2);  v_index = 32'(index2);  v_coef = 16'(coef2);
    end else begin
      v_valid = valid4;  v_done = done4;
      v_bank  = 16'(bank4);  v_index = 32'(index4);  v_coef = 16'(coef4);
    end
  end

  // ---------------- model ----------------
  function automatic int m_addr(int d, int i, int k, int lg, int nd);
    int nb = lg * nd;
    int w  = (d << (lg * (nd - 1))) | i;
    int sh = lg * k;
    return ((w >> sh) | (w << (nb - sh))) & ((1 << nb) - 1);
  endfunction

  function automatic int m_bank(int a, int lg, int nd);
    int s = 0;
    for (int j = 0; j < nd; j++) s += (a >> (j * lg)) & ((1 << lg) - 1);
    return s % (1 << lg);
  endfunction

  function automatic int m_coef(int i, int k, int lg);
    return (i >> (lg * k)) << (lg * k);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_start(input bit v);
    if (sel == 0) start2 = v; else start4 = v;
  endtask

  // Rebuild the flat binary address of operand d on the radix-2 instance.
  function automatic int flat2(int d);
    int b   = (v_bank  >> d) & 1;
    int idx = (v_index >> (3 * d)) & 7;
    int low = (b - $countones(idx[2:0])) & 1;
    return idx * 2 + low;
  endfunction

  task automatic run_xform(input int which, input int gap, input int noise_pct);
    int lg = (which == 0) ? 1 : 2;
    int nd = (which == 0) ? 4 : 3;
    int r  = 1 << lg;
    int nb = 1 << (lg * (nd - 1));
    bit noisy = 1'b0;
    int s1_lo [8] = '{0, 8, 1, 9, 2, 10, 3, 11};
    sel = which;
    repeat (gap) @(negedge clk);
    set_start(1'b1);
    @(negedge clk);
    set_start(1'b0);
    for (int k = 0; k < nd; k++) begin
      for (int i = 0; i < nb; i++) begin
        bit last = (k == nd - 1) && (i == nb - 1);
        chk(v_valid == 1'b1, noisy ? "R10 valid kept" : "R2 valid", int'(v_valid), 1);
        chk(v_done == 1'b0, "R9 done low while busy", int'(v_done), 0);
        chk(int'(v_coef) == m_coef(i, k, lg), noisy ? "R10 R8 coef" : "R3 R8 coef",
            int'(v_coef), m_coef(i, k, lg));
        for (int d = 0; d < r; d++) begin
          int a   = m_addr(d, i, k, lg, nd);
          int ab  = (v_bank  >> (d * lg)) & (r - 1);
          int ai  = (v_index >> (d * lg * (nd - 1))) & (nb - 1);
          chk(ab == m_bank(a, lg, nd), "R6 bank", ab, m_bank(a, lg, nd));
          chk(ai == (a >> lg), "R4 R7 index", ai, a >> lg);
        end
        if (which == 0) begin
          if (k == 0) begin
            chk(flat2(0) == i,     "R5 stage0 lo", flat2(0), i);
            chk(flat2(1) == i + 8, "R5 stage0 hi", flat2(1), i + 8);
          end else if (k == 1) begin
            chk(flat2(0) == s1_lo[i],     "R5 stage1 lo", flat2(0), s1_lo[i]);
            chk(flat2(1) == s1_lo[i] + 4, "R5 stage1 hi", flat2(1), s1_lo[i] + 4);
          end else if (k == 3) begin
            chk(flat2(0) == 2 * i,     "R5 last lo", flat2(0), 2 * i);
            chk(flat2(1) == 2 * i + 1, "R5 last hi", flat2(1), 2 * i + 1);
          end
        end
        noisy = !last && (($urandom % 100) < noise_pct);
        set_start(noisy);
        @(negedge clk);
      end
    end
    set_start(1'b0);
    chk(v_valid == 1'b0, "R2 R9 valid ends", int'(v_valid), 0);
    chk(v_done == 1'b1,  "R9 done pulse", int'(v_done), 1);
  endtask

  initial begin
    tests = 0; fails = 0; sel = 0;
    void'($urandom(32'h5EED_0F17));
    rst_n = 1'b0; start2 = 1'b0; start4 = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid2 == 1'b0 && done2 == 1'b0, "R1 reset r2", int'({valid2, done2}), 0);
    chk(valid4 == 1'b0 && done4 == 1'b0, "R1 reset r4", int'({valid4, done4}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(valid2 == 1'b0 && done2 == 1'b0, "R1 idle r2", int'({valid2, done2}), 0);
    chk(valid4 == 1'b0 && done4 == 1'b0, "R1 idle r4", int'({valid4, done4}), 0);

    run_xform(0, 0, 0);
    run_xform(0, 0, 100);   // back-to-back restart during done, start held busy
    for (int t = 0; t < 5; t++) run_xform(0, 1 + ($urandom % 5), 30);
    run_xform(1, 2, 0);
    run_xform(1, 0, 100);
    for (int t = 0; t < 3; t++) run_xform(1, 1 + ($urandom % 5), 30);

    sel = 0;
    @(negedge clk);
    chk(done2 == 1'b0 && valid2 == 1'b0, "R9 done one cycle r2", int'({valid2, done2}), 0);
    chk(done4 == 1'b0 && valid4 == 1'b0, "R9 done one cycle r4", int'({valid4, done4}), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule